// File: doc/BRIEF.md
# Cache Write-Path Error Injector

This block sits between a cache controller and the tag and data SRAM arrays. It corrupts write traffic on purpose so that error-detection logic further down the path can be tested. Software programs the block over a small word-addressed register bus. It writes data-mask words that cover the full 64-bit data path. It also writes one control word that holds a tag-injection enable, a data-injection enable, a checkbit-mirror enable and an 8-bit checkbit mask.

Every tag or data array write passes through one register stage. The block generates the 8 checkbits for each 64-bit data word from the unmodified write data. When injection is enabled, the block flips the selected data bits and checkbits. In mirror mode it replaces the checkbits with the top data byte before it applies the checkbit mask. On tag writes the parity bit can be inverted. Each injection stays in force for every write until software clears its enable.

Top module: `wr_err_inject`

## Requirements
- R1: After reset every register reads as zero, and neither array write strobe is asserted.
- R2: Register offsets are 0 for the mask of data bits 31:0, 1 for the mask of data bits 63:32 and 2 for control. Offset 3 reads zero. The control word uses LSB-0 numbering: bit 16 is tag-injection enable, bit 9 is mirror enable, bit 8 is data-injection enable and bits 7:0 are the checkbit mask. All other control bits read as zero and ignore writes. Read data is combinational and is zero when the read enable is low.
- R3: A write request on either array port appears at the array outputs one clock later, with the same address. The output strobe follows the input strobe with that same one-cycle delay.
- R4: Checkbits follow a Hamming code. Data bit i takes the (i+1)-th integer that is at least 3 and not a power of two as its position. Checkbit j (j = 0..6) is the XOR of the data bits whose position has bit j set. Checkbit 7 is the XOR of all 64 data bits and checkbits 0..6. With data 1 the checkbits are 0x83.
- R5: While data injection is clear, data and checkbits pass unchanged, whatever the masks, the checkbit mask and the mirror enable hold.
- R6: While data injection is set, every data bit whose mask bit is set is inverted. The mask at offset 1 covers bits 63:32.
- R7: While data injection is set, the checkbit mask inverts the matching checkbits.
- R8: While mirror and data injection are both set, the checkbit byte is data bits 63:56 of the unmodified write, XORed with the checkbit mask.
- R9: The tag parity output is the XOR of the tag bits, inverted while tag injection is set. The tag bits and the address pass unchanged.
- R10: Injection applies to every write while its enable is set, including back-to-back writes. Clearing the enable restores pass-through on the next write.
- R11: The tag enable has no effect on data writes, and the data enable has no effect on tag writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_re_i | input | 1 | Register read enable |
| reg_addr_i | input | 2 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| tag_we_i | input | 1 | Tag write request from controller |
| tag_addr_i | input | 8 | Tag write address |
| tag_wdata_i | input | 20 | Tag write bits |
| tag_we_o | output | 1 | Tag array write strobe |
| tag_addr_o | output | 8 | Tag array address |
| tag_wdata_o | output | 20 | Tag array bits |
| tag_par_o | output | 1 | Tag array parity bit |
| data_we_i | input | 1 | Data write request from controller |
| data_addr_i | input | 10 | Data write address |
| data_wdata_i | input | 64 | Data write word |
| data_we_o | output | 1 | Data array write strobe |
| data_addr_o | output | 10 | Data array address |
| data_wdata_o | output | 64 | Data array word |
| data_ecc_o | output | 8 | Data array checkbits |

## Verification
The hardest case to reach is mirror mode combined with both data masks and the checkbit mask. The mirrored byte must come from the data before masking, so a fault that takes it after masking only shows when the mask touches bits 63:56. The stimulus table therefore pairs mirror mode with masks that cover the top byte and with top bytes whose value differs from the generated checkbits. It also covers mirror mode with data injection off. Directed back-to-back tag writes, sent with the enable set and then with it cleared, show that injection persists and then releases.

// File: rtl/inj_pkg.sv
package inj_pkg;
  localparam int CTL_TAG_BIT = 16;
  localparam int CTL_MIR_BIT = 9;
  localparam int CTL_DAT_BIT = 8;
  localparam int ECC_W       = 8;
  localparam logic [31:0] CTL_RD_MASK = 32'h0001_03FF;

  typedef struct packed {
    logic             tag_en;
    logic             mirror_en;
    logic             data_en;
    logic [ECC_W-1:0] ecc_mask;
  } inj_ctl_t;
endpackage

// File: rtl/ecc_gen.sv
module ecc_gen #(
  parameter int DATA_W = 64,
  parameter int ECC_W  = 8
) (
  input  logic [DATA_W-1:0] d_i,
  output logic [ECC_W-1:0]  cb_o
);
  // column mask of Hamming check j: data bits whose code position has bit j set
  function automatic logic [DATA_W-1:0] col_mask(input int j);
    logic [DATA_W-1:0] m;
    int i;
    m = '0;
    i = 0;
    for (int pos = 3; pos < 4 * DATA_W; pos++) begin
      if (i < DATA_W && (pos & (pos - 1)) != 0) begin
        m[i] = ((pos >> j) & 1) != 0;
        i++;
      end
    end
    return m;
  endfunction

  logic [ECC_W-2:0] hcb;

  for (genvar j = 0; j < ECC_W - 1; j++) begin : g_col
    localparam logic [DATA_W-1:0] COL = col_mask(j);
    assign hcb[j] = ^(d_i & COL);
  end

  assign cb_o = {(^d_i) ^ (^hcb), hcb};
endmodule

// File: rtl/inj_regs.sv
module inj_regs
  import inj_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int REG_AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output inj_ctl_t          ctl_o,
  output logic [DATA_W-1:0] mask_o
);
  localparam int NUM_MASK = DATA_W / 32;
  localparam logic [REG_AW-1:0] CTL_OFS = REG_AW'(NUM_MASK);

  logic [31:0] mask_q [NUM_MASK];
  inj_ctl_t    ctl_q;

  for (genvar w = 0; w < NUM_MASK; w++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mask_q[w] <= '0;
      else if (we_i && addr_i == REG_AW'(w))      mask_q[w] <= wdata_i;
    end
    assign mask_o[w*32 +: 32] = mask_q[w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (we_i && addr_i == CTL_OFS) begin
      ctl_q.tag_en    <= wdata_i[CTL_TAG_BIT];
      ctl_q.mirror_en <= wdata_i[CTL_MIR_BIT];
      ctl_q.data_en   <= wdata_i[CTL_DAT_BIT];
      ctl_q.ecc_mask  <= wdata_i[ECC_W-1:0];
    end
  end

  // reserved write bits are dropped
  logic unused_rsvd;
  assign unused_rsvd = ^{wdata_i[31:CTL_TAG_BIT+1], wdata_i[CTL_TAG_BIT-1:CTL_MIR_BIT+1]};

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      for (int w = 0; w < NUM_MASK; w++)
        if (addr_i == REG_AW'(w)) rdata_o = mask_q[w];
      if (addr_i == CTL_OFS) begin
        rdata_o[CTL_TAG_BIT] = ctl_q.tag_en;
        rdata_o[CTL_MIR_BIT] = ctl_q.mirror_en;
        rdata_o[CTL_DAT_BIT] = ctl_q.data_en;
        rdata_o[ECC_W-1:0]   = ctl_q.ecc_mask;
      end
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/inj_tag_path.sv
module inj_tag_path #(
  parameter int TAG_W  = 20,
  parameter int TAG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tag_en_i,
  input  logic              we_i,
  input  logic [TAG_AW-1:0] addr_i,
  input  logic [TAG_W-1:0]  wdata_i,
  output logic              we_o,
  output logic [TAG_AW-1:0] addr_o,
  output logic [TAG_W-1:0]  wdata_o,
  output logic              par_o
);
  logic par_d;
  assign par_d = (^wdata_i) ^ tag_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      par_o   <= 1'b0;
    end else begin
      we_o <= we_i;
      if (we_i) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
        par_o   <= par_d;
      end
    end
  end
endmodule

// File: rtl/inj_data_path.sv
module inj_data_path
  import inj_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int DADDR_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  inj_ctl_t           ctl_i,
  input  logic [DATA_W-1:0]  mask_i,
  input  logic               we_i,
  input  logic [DADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic               we_o,
  output logic [DADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0]  wdata_o,
  output logic [ECC_W-1:0]   ecc_o
);
  logic [ECC_W-1:0]  ecc_raw, ecc_base, ecc_d;
  logic [DATA_W-1:0] data_d;

  ecc_gen #(.DATA_W(DATA_W), .ECC_W(ECC_W)) u_ecc (
    .d_i  (wdata_i),
    .cb_o (ecc_raw)
  );

  // mirror byte and checkbits both come from the unmodified word
  always_comb begin
    ecc_base = ctl_i.mirror_en ? wdata_i[DATA_W-1 -: ECC_W] : ecc_raw;
    if (ctl_i.data_en) begin
      ecc_d  = ecc_base ^ ctl_i.ecc_mask;
      data_d = wdata_i ^ mask_i;
    end else begin
      ecc_d  = ecc_raw;
      data_d = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      ecc_o   <= '0;
    end else begin
      we_o <= we_i;
      if (we_i) begin
        addr_o  <= addr_i;
        wdata_o <= data_d;
        ecc_o   <= ecc_d;
      end
    end
  end
endmodule

// File: rtl/wr_err_inject.sv
module wr_err_inject
  import inj_pkg::*;
#(
  parameter  int DATA_W  = 64,
  parameter  int TAG_W   = 20,
  parameter  int TAG_AW  = 8,
  parameter  int DADDR_W = 10,
  localparam int NUM_MASK = DATA_W / 32,
  localparam int REG_AW   = $clog2(NUM_MASK + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic               reg_re_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               tag_we_i,
  input  logic [TAG_AW-1:0]  tag_addr_i,
  input  logic [TAG_W-1:0]   tag_wdata_i,
  output logic               tag_we_o,
  output logic [TAG_AW-1:0]  tag_addr_o,
  output logic [TAG_W-1:0]   tag_wdata_o,
  output logic               tag_par_o,
  input  logic               data_we_i,
  input  logic [DADDR_W-1:0] data_addr_i,
  input  logic [DATA_W-1:0]  data_wdata_i,
  output logic               data_we_o,
  output logic [DADDR_W-1:0] data_addr_o,
  output logic [DATA_W-1:0]  data_wdata_o,
  output logic [ECC_W-1:0]   data_ecc_o
);
  inj_ctl_t          ctl_w;
  logic [DATA_W-1:0] mask_w;

  inj_regs #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .re_i    (reg_re_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .ctl_o   (ctl_w),
    .mask_o  (mask_w)
  );

  inj_tag_path #(.TAG_W(TAG_W), .TAG_AW(TAG_AW)) u_tag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tag_en_i (ctl_w.tag_en),
    .we_i     (tag_we_i),
    .addr_i   (tag_addr_i),
    .wdata_i  (tag_wdata_i),
    .we_o     (tag_we_o),
    .addr_o   (tag_addr_o),
    .wdata_o  (tag_wdata_o),
    .par_o    (tag_par_o)
  );

  inj_data_path #(.DATA_W(DATA_W), .DADDR_W(DADDR_W)) u_data (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctl_i   (ctl_w),
    .mask_i  (mask_w),
    .we_i    (data_we_i),
    .addr_i  (data_addr_i),
    .wdata_i (data_wdata_i),
    .we_o    (data_we_o),
    .addr_o  (data_addr_o),
    .wdata_o (data_wdata_o),
    .ecc_o   (data_ecc_o)
  );
endmodule

// File: rtl/wr_err_inject_chk.sv
module wr_err_inject_chk
  import inj_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 20,
  parameter int REG_AW = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_re_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [31:0]       reg_rdata_o,
  input logic              tag_we_i,
  input logic [TAG_W-1:0]  tag_wdata_i,
  input logic              tag_we_o,
  input logic [TAG_W-1:0]  tag_wdata_o,
  input logic              tag_par_o,
  input logic              data_we_i,
  input logic              data_we_o,
  input logic [DATA_W-1:0] data_wdata_o,
  input logic [ECC_W-1:0]  data_ecc_o,
  input inj_ctl_t          ctl_i,
  input logic [DATA_W-1:0] mask_i
);
  localparam logic [REG_AW-1:0] CTL_OFS = REG_AW'(DATA_W / 32);

  inj_ctl_t          ctl_d;
  logic [DATA_W-1:0] mask_d, orig_data;
  logic [ECC_W-1:0]  ecc_out, ecc_orig;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_d  <= '0;
      mask_d <= '0;
    end else begin
      ctl_d  <= ctl_i;
      mask_d <= mask_i;
    end
  end

  assign orig_data = data_wdata_o ^ (ctl_d.data_en ? mask_d : '0);

  ecc_gen #(.DATA_W(DATA_W), .ECC_W(ECC_W)) u_ecc_out  (.d_i(data_wdata_o), .cb_o(ecc_out));
  ecc_gen #(.DATA_W(DATA_W), .ECC_W(ECC_W)) u_ecc_orig (.d_i(orig_data),    .cb_o(ecc_orig));

  AST_DATA_WE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni) data_we_i |=> data_we_o); // R3
  AST_DATA_WE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !data_we_i |=> !data_we_o); // R3
  AST_TAG_WE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni) tag_we_i |=> tag_we_o); // R3
  AST_TAG_BITS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni) tag_we_i |=> tag_wdata_o == $past(tag_wdata_i)); // R9
  AST_TAG_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni) tag_we_o |-> tag_par_o == ((^tag_wdata_o) ^ ctl_d.tag_en)); // R9
  AST_DATA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni) (data_we_o && !ctl_d.data_en) |-> data_ecc_o == ecc_out); // R5
  AST_ECC_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni) (data_we_o && ctl_d.data_en && !ctl_d.mirror_en) |-> (data_ecc_o ^ ctl_d.ecc_mask) == ecc_orig); // R7
  AST_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni) (data_we_o && ctl_d.data_en && ctl_d.mirror_en) |-> (data_ecc_o ^ ctl_d.ecc_mask) == orig_data[DATA_W-1 -: ECC_W]); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) (reg_re_i && reg_addr_i == CTL_OFS) |-> (reg_rdata_o & ~CTL_RD_MASK) == '0); // R2
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !reg_re_i |-> reg_rdata_o == '0); // R2
endmodule

bind wr_err_inject wr_err_inject_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W), .REG_AW(REG_AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_re_i     (reg_re_i),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o),
  .tag_we_i     (tag_we_i),
  .tag_wdata_i  (tag_wdata_i),
  .tag_we_o     (tag_we_o),
  .tag_wdata_o  (tag_wdata_o),
  .tag_par_o    (tag_par_o),
  .data_we_i    (data_we_i),
  .data_we_o    (data_we_o),
  .data_wdata_o (data_wdata_o),
  .data_ecc_o   (data_ecc_o),
  .ctl_i        (ctl_w),
  .mask_i       (mask_w)
);

// File: tb/sim_wr_err_inject.sv
module sim_wr_err_inject;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        tag_we = 1'b0;
  logic [7:0]  tag_addr = '0;
  logic [19:0] tag_wdata = '0;
  logic        tag_we_o, tag_par_o;
  logic [7:0]  tag_addr_o;
  logic [19:0] tag_wdata_o;
  logic        data_we = 1'b0;
  logic [9:0]  data_addr = '0;
  logic [63:0] data_wdata = '0;
  logic        data_we_o;
  logic [9:0]  data_addr_o;
  logic [63:0] data_wdata_o;
  logic [7:0]  data_ecc_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wr_err_inject u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tag_we_i(tag_we), .tag_addr_i(tag_addr), .tag_wdata_i(tag_wdata),
    .tag_we_o(tag_we_o), .tag_addr_o(tag_addr_o), .tag_wdata_o(tag_wdata_o), .tag_par_o(tag_par_o),
    .data_we_i(data_we), .data_addr_i(data_addr), .data_wdata_i(data_wdata),
    .data_we_o(data_we_o), .data_addr_o(data_addr_o), .data_wdata_o(data_wdata_o), .data_ecc_o(data_ecc_o)
  );

  // {ctl, mask_lo, mask_hi, data_hi, data_lo}
  localparam logic [159:0] VEC [8] = '{
    {32'h0000_03FF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0123_4567},
    {32'h0000_0100, 32'h0000_0001, 32'h8000_0000, 32'h1111_2222, 32'h3333_4444},
    {32'h0000_01A5, 32'hFFFF_0000, 32'h0000_0000, 32'h0F0F_0F0F, 32'hF0F0_F0F0},
    {32'h0000_033C, 32'h0000_00FF, 32'hFF00_0000, 32'hD4C3_B2A1, 32'h9988_7766},
    {32'h0000_0200, 32'hAAAA_AAAA, 32'h5555_5555, 32'h7E00_0000, 32'h0000_0001},
    {32'h0000_0300, 32'h0000_0000, 32'h0000_0000, 32'h5A00_00FF, 32'h0000_0000},
    {32'h0001_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hCAFE_F00D, 32'h8BAD_F00D},
    {32'h0000_0381, 32'h1234_5678, 32'h0F00_0000, 32'h3C12_0000, 32'h00FF_00FF}
  };

  function automatic logic [7:0] ref_ecc(input logic [63:0] d);
    logic [7:0] c = '0;
    int i = 0;
    for (int pos = 3; i < 64; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int j = 0; j < 7; j++) if (pos[j]) c[j] ^= d[i];
        i++;
      end
    end
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  function automatic logic [71:0] exp_wr(input logic [31:0] ctl, input logic [63:0] m, input logic [63:0] d);
    logic [7:0] base;
    if (!ctl[8]) return {ref_ecc(d), d};
    base = ctl[9] ? d[63:56] : ref_ecc(d);
    return {base ^ ctl[7:0], d ^ m};
  endfunction

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    reg_re = 1'b0;
  endtask

  // result valid at the negedge after the capturing posedge
  task automatic data_wr(input logic [63:0] d, input logic [9:0] a);
    @(negedge clk); data_we = 1'b1; data_wdata = d; data_addr = a;
    @(negedge clk); data_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rv;
    logic [71:0] e;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_rd(2'(a), rv);
      chk("R1 reg reset", 72'(rv), 72'h0);
    end
    chk("R1 write strobes idle", 72'({tag_we_o, data_we_o}), 72'h0);

    // R2 readback and reserved bits
    reg_wr(2'd2, 32'hFFFF_FFFF);
    reg_rd(2'd2, rv);
    chk("R2 ctl reserved bits", 72'(rv), 72'h0001_03FF);
    reg_wr(2'd1, 32'hA5A5_0F0F);
    reg_rd(2'd1, rv);
    chk("R2 mask hi readback", 72'(rv), 72'hA5A5_0F0F);
    reg_wr(2'd3, 32'hFFFF_FFFF);
    reg_rd(2'd3, rv);
    chk("R2 offset 3 reads zero", 72'(rv), 72'h0);
    @(negedge clk); reg_addr = 2'd2; #1;
    chk("R2 read data zero without enable", 72'(reg_rdata), 72'h0);
    reg_wr(2'd2, 32'h0);

    // R4 known checkbits, R3 latency and address
    @(negedge clk); data_we = 1'b1; data_wdata = 64'h1; data_addr = 10'h2A5;
    #1 chk("R3 no output before clock", 72'(data_we_o), 72'h0);
    @(negedge clk); data_we = 1'b0;
    chk("R3 strobe after one cycle", 72'(data_we_o), 72'h1);
    chk("R3 address passes", 72'(data_addr_o), 72'h2A5);
    chk("R4 checkbits of 1", 72'(data_ecc_o), 72'h83);
    @(negedge clk);
    chk("R3 strobe drops", 72'(data_we_o), 72'h0);

    // vector table: R5 R6 R7 R8 R11
    for (int k = 0; k < 8; k++) begin
      logic [31:0] c, ml, mh;
      logic [63:0] d;
      {c, ml, mh, d} = VEC[k];
      reg_wr(2'd0, ml);
      reg_wr(2'd1, mh);
      reg_wr(2'd2, c);
      data_wr(d, 10'(k));
      e = exp_wr(c, {mh, ml}, d);
      chk($sformatf("R5 R6 R7 R8 R11 vector %0d", k), {data_ecc_o, data_wdata_o}, e);
    end

    // R10 data injection persists back-to-back, then releases
    reg_wr(2'd0, 32'h0000_00F0);
    reg_wr(2'd1, 32'h0);
    reg_wr(2'd2, 32'h0000_0111);
    @(negedge clk); data_we = 1'b1; data_wdata = 64'hAB;
    @(negedge clk); data_wdata = 64'hCD00;
    chk("R10 first data write", {data_ecc_o, data_wdata_o}, exp_wr(32'h111, 64'hF0, 64'hAB));
    @(negedge clk); data_we = 1'b0;
    chk("R10 second data write", {data_ecc_o, data_wdata_o}, exp_wr(32'h111, 64'hF0, 64'hCD00));
    reg_wr(2'd2, 32'h0);
    data_wr(64'hAB, 10'h0);
    chk("R10 data released", {data_ecc_o, data_wdata_o}, {ref_ecc(64'hAB), 64'hAB});

    // R9 tag parity pass, R11 data enable ignored by tag
    reg_wr(2'd2, 32'h0000_01FF);
    @(negedge clk); tag_we = 1'b1; tag_wdata = 20'h0_0007; tag_addr = 8'h3C;
    @(negedge clk); tag_we = 1'b0;
    chk("R9 R11 tag parity pass", {tag_par_o, tag_wdata_o, tag_addr_o}, {1'b1, 20'h0_0007, 8'h3C});

    // R9 R10 tag injection back-to-back
    reg_wr(2'd2, 32'h0001_0000);
    @(negedge clk); tag_we = 1'b1; tag_wdata = 20'h0_0003;
    @(negedge clk); tag_wdata = 20'hF_0001;
    chk("R9 R10 tag first inverted", {tag_par_o, tag_wdata_o}, {1'b1, 20'h0_0003});
    @(negedge clk); tag_we = 1'b0;
    chk("R9 R10 tag second inverted", {tag_par_o, tag_wdata_o}, {1'b0, 20'hF_0001});
    reg_wr(2'd2, 32'h0);
    @(negedge clk); tag_we = 1'b1; tag_wdata = 20'h0_0003;
    @(negedge clk); tag_we = 1'b0;
    chk("R10 tag released", 72'(tag_par_o), 72'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule